// File: doc/BRIEF.md
# Multi-Class Physical Register Free List

This block keeps track of which physical register tags are free for a renaming stage. It holds six separate pools, one per register class: integer, floating point, vector, vector element, predicate and condition code. Each pool is a first-in first-out ring, so tags are handed out again in the order they came back. A rename stage asks for a tag of a given class and gets the oldest free tag of that class in the same cycle. Retirement returns tags one at a time on a single release port, or several tags of one class at once on a burst port.

A release is steered to a pool by its 3-bit class code. The block checks for the usual misuse of a free list and reports it on one-cycle error pulses: a class code that names no pool, a burst whose first and last lanes disagree on class, an allocation from an empty pool, a release into a pool with no room left (a double free), and any use of whichever of the two vector pools the mode input has switched off. Each pool shows its current count and a non-empty flag.

Top module: `regfree_list`

## Requirements
- R1: After reset, pool p (p = 0..5) holds DEPTH-RSV tags, the values p*DEPTH+RSV up to p*DEPTH+DEPTH-1 in ascending order of hand-out; each count reads DEPTH-RSV and every non-empty flag is 1.
- R2: Within a pool, allocation returns the oldest stored tag, and a released tag is handed out only after every tag that was already in that pool.
- R3: Class codes are 0 integer, 1 floating point, 2 vector, 3 vector element, 4 predicate, 5 condition code; a released tag is stored only in the pool its code names and the counts of the other pools do not change.
- R4: Codes 6 and 7 are invalid: a release or allocation with such a code stores or grants nothing and raises err_class in the following cycle.
- R5: A burst of bfree_cnt tags (1 to BURST_MAX, lane k in bits k*TAG_W and class in bits k*3) enters its pool in one cycle in lane order; a single release of the same class in the same cycle is placed after the burst tags.
- R6: A burst with bfree_cnt equal to zero stores nothing and raises no error, whatever its lane classes hold.
- R7: If the class of lane 0 differs from the class of lane bfree_cnt-1, the whole burst is dropped and err_mixed is raised in the following cycle.
- R8: An allocation of a valid, active class whose pool is empty is refused (alloc_gnt 0) and raises err_underflow in the following cycle.
- R9: With vec_sel 0 the vector pool is active and the vector-element pool is not; with vec_sel 1 the reverse. Any release or allocation aimed at the inactive pool stores or grants nothing and raises err_mode in the following cycle.
- R10: Releases beyond the free room of a pool (DEPTH minus count, plus one if that pool is popped in the same cycle) are dropped lane by lane from the end, the count stops at DEPTH, and err_overflow is raised in the following cycle.
- R11: An allocation and a release to the same pool in one cycle are both carried out, even when the pool is full, and its count stays the same.
- R12: alloc_gnt and alloc_tag respond in the cycle of the request; counts and flags change at the next clock edge; every error output is a pulse one cycle after the offending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_sel | input | 1 | 0: vector pool active, 1: vector-element pool active |
| alloc_req | input | 1 | Allocation request |
| alloc_cls | input | 3 | Class of the allocation |
| alloc_gnt | output | 1 | Allocation granted this cycle |
| alloc_tag | output | TAG_W | Granted tag (valid with alloc_gnt) |
| free_vld | input | 1 | Single release valid |
| free_cls | input | 3 | Class of the single release |
| free_tag | input | TAG_W | Tag of the single release |
| bfree_cnt | input | $clog2(BURST_MAX+1) | Number of burst lanes in use |
| bfree_cls | input | 3*BURST_MAX | Class of each burst lane |
| bfree_tag | input | TAG_W*BURST_MAX | Tag of each burst lane |
| pool_cnt | output | 6*CNT_W | Free count of each pool, pool p in bits p*CNT_W |
| pool_nonempty | output | 6 | Per-pool non-empty flag |
| err_class | output | 1 | Invalid class code seen |
| err_mixed | output | 1 | Burst with differing first and last class |
| err_underflow | output | 1 | Allocation from an empty pool |
| err_overflow | output | 1 | Release into a pool without room |
| err_mode | output | 1 | Use of the inactive vector pool |

## Verification
The allocate path is driven with repeated single requests that walk a pool past its preloaded tags into tags returned later, which separates true oldest-first ordering from a stack or a fixed preload sequence. Releases are sent singly, as bursts, and as a burst plus a single release in the same cycle, so lane order and the position of the single tag can be told apart. Edge patterns pair an allocation with a release on a full pool, overfill a pool by one burst, and send zero-length, mixed and invalid-class bursts, which distinguishes a correct room computation from one that ignores the pop or drops the whole burst.

// File: rtl/regfree_pkg.sv
package regfree_pkg;

  localparam int NPOOL = 6;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_INT  = 3'd0,
    CLS_FP   = 3'd1,
    CLS_VEC  = 3'd2,
    CLS_VEL  = 3'd3,
    CLS_PRED = 3'd4,
    CLS_CC   = 3'd5
  } cls_e;

  function automatic logic cls_valid(logic [CLS_W-1:0] c);
    return c < 3'd6;
  endfunction

  // vsel = 0 keeps the vector pool, vsel = 1 keeps the element pool
  function automatic logic cls_active(logic [CLS_W-1:0] c, logic vsel);
    return !((c == CLS_VEC && vsel) || (c == CLS_VEL && !vsel));
  endfunction

endpackage

// File: rtl/regfree_pool.sv
module regfree_pool #(
  parameter int DEPTH = 8,
  parameter int RSV   = 2,
  parameter int TAG_W = 6,
  parameter int LANES = 4,
  parameter int BASE  = 0,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LN_W  = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop,
  input  logic [LN_W-1:0]  push_n,
  input  logic [TAG_W-1:0] push_tag [LANES],
  output logic [TAG_W-1:0] head_tag,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);

  logic [TAG_W-1:0] mem    [DEPTH];
  logic [TAG_W-1:0] mem_nx [DEPTH];
  logic [PTR_W-1:0] head, head_nx;
  logic [CNT_W-1:0] cnt_nx;
  logic             upd;

  always_comb begin
    int room;
    int take;
    room     = DEPTH - int'(cnt) + int'(pop);
    take     = (int'(push_n) > room) ? room : int'(push_n);
    ovf      = int'(push_n) > room;
    cnt_nx   = CNT_W'(int'(cnt) + take - int'(pop));
    head_nx  = head + PTR_W'(pop);
    upd      = pop || (push_n != '0);
    head_tag = mem[head];
    mem_nx   = mem;
    for (int k = 0; k < LANES; k++) begin
      if (k < take) mem_nx[PTR_W'(int'(head) + int'(cnt) + k)] = push_tag[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      cnt  <= CNT_W'(DEPTH - RSV);
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= (i < DEPTH - RSV) ? TAG_W'(BASE + RSV + i) : '0;
      end
    end else if (upd) begin
      head <= head_nx;
      cnt  <= cnt_nx;
      mem  <= mem_nx;
    end
  end

endmodule

// File: rtl/regfree_steer.sv
module regfree_steer
  import regfree_pkg::*;
#(
  parameter int TAG_W     = 6,
  parameter int BURST_MAX = 3,
  localparam int LANES = BURST_MAX + 1,
  localparam int LN_W  = $clog2(LANES + 1),
  localparam int BC_W  = $clog2(BURST_MAX + 1)
) (
  input  logic             vec_sel,
  input  logic             free_vld,
  input  logic [CLS_W-1:0] free_cls,
  input  logic [TAG_W-1:0] free_tag,
  input  logic [BC_W-1:0]  b_cnt,
  input  logic [CLS_W-1:0] b_cls [BURST_MAX],
  input  logic [TAG_W-1:0] b_tag [BURST_MAX],
  output logic [LN_W-1:0]  push_n   [NPOOL],
  output logic [TAG_W-1:0] push_tag [NPOOL][LANES],
  output logic             e_class,
  output logic             e_mixed,
  output logic             e_mode
);

  logic [CLS_W-1:0] bcls;
  logic             b_any, b_good, s_good;

  always_comb begin
    int beff;
    int n;
    beff    = (int'(b_cnt) > BURST_MAX) ? BURST_MAX : int'(b_cnt);
    b_any   = beff > 0;
    bcls    = b_cls[0];
    e_mixed = b_any && (b_cls[b_any ? beff - 1 : 0] != bcls);
    b_good  = b_any && !e_mixed && cls_valid(bcls) && cls_active(bcls, vec_sel);
    s_good  = free_vld && cls_valid(free_cls) && cls_active(free_cls, vec_sel);
    e_class = (free_vld && !cls_valid(free_cls)) ||
              (b_any && !e_mixed && !cls_valid(bcls));
    e_mode  = (free_vld && cls_valid(free_cls) && !cls_active(free_cls, vec_sel)) ||
              (b_any && !e_mixed && cls_valid(bcls) && !cls_active(bcls, vec_sel));
    for (int p = 0; p < NPOOL; p++) begin
      n = 0;
      for (int k = 0; k < LANES; k++) push_tag[p][k] = '0;
      if (b_good && int'(bcls) == p) begin
        for (int k = 0; k < BURST_MAX; k++) begin
          if (k < beff) push_tag[p][k] = b_tag[k];
        end
        n = beff;
      end
      if (s_good && int'(free_cls) == p) begin
        push_tag[p][n] = free_tag;
        n = n + 1;
      end
      push_n[p] = LN_W'(n);
    end
  end

endmodule

// File: rtl/regfree_list.sv
module regfree_list
  import regfree_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int RSV       = 2,
  parameter int TAG_W     = 6,
  parameter int BURST_MAX = 3,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int BC_W  = $clog2(BURST_MAX + 1),
  localparam int LANES = BURST_MAX + 1,
  localparam int LN_W  = $clog2(LANES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       vec_sel,
  input  logic                       alloc_req,
  input  logic [2:0]                 alloc_cls,
  output logic                       alloc_gnt,
  output logic [TAG_W-1:0]           alloc_tag,
  input  logic                       free_vld,
  input  logic [2:0]                 free_cls,
  input  logic [TAG_W-1:0]           free_tag,
  input  logic [BC_W-1:0]            bfree_cnt,
  input  logic [3*BURST_MAX-1:0]     bfree_cls,
  input  logic [TAG_W*BURST_MAX-1:0] bfree_tag,
  output logic [NPOOL*CNT_W-1:0]     pool_cnt,
  output logic [NPOOL-1:0]           pool_nonempty,
  output logic                       err_class,
  output logic                       err_mixed,
  output logic                       err_underflow,
  output logic                       err_overflow,
  output logic                       err_mode
);

  logic [CLS_W-1:0] bcls_a [BURST_MAX];
  logic [TAG_W-1:0] btag_a [BURST_MAX];
  logic [LN_W-1:0]  push_n   [NPOOL];
  logic [TAG_W-1:0] push_tag [NPOOL][LANES];
  logic [TAG_W-1:0] head_a [NPOOL];
  logic [CNT_W-1:0] cnt_a  [NPOOL];
  logic [NPOOL-1:0] ovf_a, pop_a;
  logic             f_class, f_mixed, f_mode;
  logic             a_ok, a_ne;
  logic             class_nx, under_nx, mode_nx, ovf_nx;

  for (genvar k = 0; k < BURST_MAX; k++) begin : g_lane
    assign bcls_a[k] = bfree_cls[k*3 +: 3];
    assign btag_a[k] = bfree_tag[k*TAG_W +: TAG_W];
  end

  regfree_steer #(.TAG_W(TAG_W), .BURST_MAX(BURST_MAX)) u_steer (
    .vec_sel  (vec_sel),
    .free_vld (free_vld),
    .free_cls (free_cls),
    .free_tag (free_tag),
    .b_cnt    (bfree_cnt),
    .b_cls    (bcls_a),
    .b_tag    (btag_a),
    .push_n   (push_n),
    .push_tag (push_tag),
    .e_class  (f_class),
    .e_mixed  (f_mixed),
    .e_mode   (f_mode)
  );

  for (genvar p = 0; p < NPOOL; p++) begin : g_pool
    assign pop_a[p] = alloc_gnt && (int'(alloc_cls) == p);
    regfree_pool #(
      .DEPTH(DEPTH), .RSV(RSV), .TAG_W(TAG_W), .LANES(LANES), .BASE(p * DEPTH)
    ) u_pool (
      .clk      (clk),
      .rst_n    (rst_n),
      .pop      (pop_a[p]),
      .push_n   (push_n[p]),
      .push_tag (push_tag[p]),
      .head_tag (head_a[p]),
      .cnt      (cnt_a[p]),
      .ovf      (ovf_a[p])
    );
    assign pool_cnt[p*CNT_W +: CNT_W] = cnt_a[p];
    assign pool_nonempty[p]           = cnt_a[p] != '0;
  end

  always_comb begin
    a_ok      = cls_valid(alloc_cls) && cls_active(alloc_cls, vec_sel);
    a_ne      = 1'b0;
    alloc_tag = '0;
    if (cls_valid(alloc_cls)) begin
      a_ne      = pool_nonempty[alloc_cls];
      alloc_tag = head_a[alloc_cls];
    end
    alloc_gnt = alloc_req && a_ok && a_ne;
    class_nx  = f_class || (alloc_req && !cls_valid(alloc_cls));
    mode_nx   = f_mode || (alloc_req && cls_valid(alloc_cls) && !a_ok);
    under_nx  = alloc_req && a_ok && !a_ne;
    ovf_nx    = |ovf_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_class     <= 1'b0;
      err_mixed     <= 1'b0;
      err_underflow <= 1'b0;
      err_overflow  <= 1'b0;
      err_mode      <= 1'b0;
    end else begin
      err_class     <= class_nx;
      err_mixed     <= f_mixed;
      err_underflow <= under_nx;
      err_overflow  <= ovf_nx;
      err_mode      <= mode_nx;
    end
  end

endmodule

// File: rtl/regfree_list_chk.sv
module regfree_list_chk #(
  parameter int DEPTH     = 8,
  parameter int RSV       = 2,
  parameter int TAG_W     = 6,
  parameter int BURST_MAX = 3,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int BC_W  = $clog2(BURST_MAX + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       vec_sel,
  input logic                       alloc_req,
  input logic [2:0]                 alloc_cls,
  input logic                       alloc_gnt,
  input logic [TAG_W-1:0]           alloc_tag,
  input logic                       free_vld,
  input logic [2:0]                 free_cls,
  input logic [TAG_W-1:0]           free_tag,
  input logic [BC_W-1:0]            bfree_cnt,
  input logic [3*BURST_MAX-1:0]     bfree_cls,
  input logic [TAG_W*BURST_MAX-1:0] bfree_tag,
  input logic [6*CNT_W-1:0]         pool_cnt,
  input logic [5:0]                 pool_nonempty,
  input logic                       err_class,
  input logic                       err_mixed,
  input logic                       err_underflow,
  input logic                       err_overflow,
  input logic                       err_mode
);

  for (genvar p = 0; p < 6; p++) begin : g_bound
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pool_cnt[p*CNT_W +: CNT_W]) <= DEPTH);  // R10
  end

  AST_GNT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_gnt |-> (alloc_cls < 3'd6) && pool_nonempty[alloc_cls]);  // R8

  AST_BAD_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (free_vld && free_cls > 3'd5) |=> err_class);  // R4

  AST_NO_GNT_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_cls > 3'd5) |-> !alloc_gnt);  // R4

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bfree_cnt == '0 && !free_vld && !alloc_req) |=> $stable(pool_cnt));  // R6

  AST_INACTIVE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    (free_vld && free_cls == 3'd2 && vec_sel) |=> err_mode);  // R9

  AST_INACTIVE_VEL: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_cls == 3'd3 && !vec_sel) |-> !alloc_gnt);  // R9

  AST_EMPTY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_cls == 3'd0 && !pool_nonempty[0]) |=> err_underflow);  // R8

endmodule

bind regfree_list regfree_list_chk #(
  .DEPTH(DEPTH), .RSV(RSV), .TAG_W(TAG_W), .BURST_MAX(BURST_MAX)
) u_chk (.*);

// File: tb/sim_regfree_list.sv
module sim_regfree_list;

  localparam int DEPTH = 8;
  localparam int RSV   = 2;
  localparam int TW    = 6;
  localparam int BM    = 3;
  localparam int CW    = 4;

  logic          clk, rst_n, vec_sel;
  logic          alloc_req;
  logic [2:0]    alloc_cls;
  logic          alloc_gnt;
  logic [TW-1:0] alloc_tag;
  logic          free_vld;
  logic [2:0]    free_cls;
  logic [TW-1:0] free_tag;
  logic [1:0]    bfree_cnt;
  logic [3*BM-1:0]  bfree_cls;
  logic [TW*BM-1:0] bfree_tag;
  logic [6*CW-1:0]  pool_cnt;
  logic [5:0]    pool_nonempty;
  logic          err_class, err_mixed, err_underflow, err_overflow, err_mode;

  int tests, fails;
  logic          gnt_s;
  logic [TW-1:0] tag_s;
  logic [6*CW-1:0] pre_s;
  logic [4:0]    errs_s;  // class, mixed, underflow, overflow, mode

  regfree_list #(.DEPTH(DEPTH), .RSV(RSV), .TAG_W(TW), .BURST_MAX(BM)) u0 (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cnt(int p);
    return int'(pool_cnt[p*CW +: CW]);
  endfunction

  task automatic step();
    #1;
    gnt_s = alloc_gnt;
    tag_s = alloc_tag;
    pre_s = pool_cnt;
    @(negedge clk);
    errs_s    = {err_class, err_mixed, err_underflow, err_overflow, err_mode};
    alloc_req = 1'b0;
    free_vld  = 1'b0;
    bfree_cnt = '0;
  endtask

  task automatic do_alloc(int c);
    alloc_req = 1'b1; alloc_cls = 3'(c);
    step();
  endtask

  task automatic do_free(int c, int t);
    free_vld = 1'b1; free_cls = 3'(c); free_tag = TW'(t);
    step();
  endtask

  task automatic set_burst(int n, int c0, int c1, int c2, int t0, int t1, int t2);
    bfree_cnt = 2'(n);
    bfree_cls = {3'(c2), 3'(c1), 3'(c0)};
    bfree_tag = {TW'(t2), TW'(t1), TW'(t0)};
  endtask

  task automatic expect_alloc(string req, int c, int t);
    do_alloc(c);
    chk(req, int'(gnt_s), 1);
    chk(req, int'(tag_s), t);
  endtask

  task automatic t_reset();
    for (int p = 0; p < 6; p++) chk("R1 count", cnt(p), DEPTH - RSV);
    chk("R1 nonempty", int'(pool_nonempty), 63);
    chk("R1 errors", int'({err_class, err_mixed, err_underflow, err_overflow, err_mode}), 0);
  endtask

  task automatic t_fifo_underflow();
    expect_alloc("R2 first", 0, 2);
    expect_alloc("R2 second", 0, 3);
    do_free(0, 2);
    chk("R2 count", cnt(0), 5);
    for (int t = 4; t <= 7; t++) expect_alloc("R2 order", 0, t);
    expect_alloc("R2 returned last", 0, 2);
    chk("R8 empty flag", int'(pool_nonempty[0]), 0);
    do_alloc(0);
    chk("R8 refused", int'(gnt_s), 0);
    chk("R8 err", int'(errs_s), 5'b00100);
    chk("R8 count", cnt(0), 0);
  endtask

  task automatic t_route_timing();
    do_free(1, 40);
    chk("R3 fp count", cnt(1), 7);
    for (int p = 2; p < 6; p++) chk("R3 other", cnt(p), 6);
    chk("R3 int", cnt(0), 0);
    do_alloc(1);
    chk("R12 gnt same cycle", int'(gnt_s), 1);
    chk("R12 tag same cycle", int'(tag_s), 10);
    chk("R12 count before edge", int'(pre_s[1*CW +: CW]), 7);
    chk("R12 count after edge", cnt(1), 6);
    chk("R12 err pulse gone", int'({err_class, err_mixed, err_underflow, err_overflow, err_mode}), 0);
  endtask

  task automatic t_bad_class();
    do_free(6, 9);
    chk("R4 free err", int'(errs_s), 5'b10000);
    for (int p = 1; p < 6; p++) chk("R4 counts", cnt(p), 6);
    do_alloc(7);
    chk("R4 alloc gnt", int'(gnt_s), 0);
    chk("R4 alloc err", int'(errs_s), 5'b10000);
  endtask

  task automatic t_burst();
    set_burst(3, 0, 0, 0, 20, 21, 22);
    free_vld = 1'b1; free_cls = 3'd0; free_tag = TW'(23);
    step();
    chk("R5 count", cnt(0), 4);
    chk("R5 no err", int'(errs_s), 0);
    for (int t = 20; t <= 23; t++) expect_alloc("R5 lane order", 0, t);
  endtask

  task automatic t_zero_burst();
    set_burst(0, 4, 5, 7, 1, 2, 3);
    step();
    chk("R6 no err", int'(errs_s), 0);
    chk("R6 pred", cnt(4), 6);
    chk("R6 cc", cnt(5), 6);
  endtask

  task automatic t_mixed();
    set_burst(2, 4, 5, 4, 50, 51, 52);
    step();
    chk("R7 err", int'(errs_s), 5'b01000);
    chk("R7 pred", cnt(4), 6);
    chk("R7 cc", cnt(5), 6);
  endtask

  task automatic t_mode();
    vec_sel = 1'b0;
    do_free(3, 9);
    chk("R9 free inactive err", int'(errs_s), 5'b00001);
    chk("R9 elem count", cnt(3), 6);
    do_alloc(3);
    chk("R9 alloc inactive", int'(gnt_s), 0);
    chk("R9 alloc err", int'(errs_s), 5'b00001);
    expect_alloc("R9 vector active", 2, 18);
    vec_sel = 1'b1;
    do_alloc(2);
    chk("R9 vector now off", int'(gnt_s), 0);
    chk("R9 vector err", int'(errs_s), 5'b00001);
    expect_alloc("R9 elem active", 3, 26);
    vec_sel = 1'b0;
  endtask

  task automatic t_overflow_simul();
    set_burst(3, 4, 4, 4, 54, 55, 56);
    step();
    chk("R10 err", int'(errs_s), 5'b00010);
    chk("R10 count full", cnt(4), 8);
    do_free(4, 57);
    chk("R10 full drop err", int'(errs_s), 5'b00010);
    chk("R10 full count", cnt(4), 8);
    alloc_req = 1'b1; alloc_cls = 3'd4;
    free_vld = 1'b1; free_cls = 3'd4; free_tag = TW'(60);
    step();
    chk("R11 gnt", int'(gnt_s), 1);
    chk("R11 tag", int'(tag_s), 34);
    chk("R11 count", cnt(4), 8);
    chk("R11 no err", int'(errs_s), 0);
    for (int t = 35; t <= 39; t++) expect_alloc("R2 drain", 4, t);
    expect_alloc("R10 kept lane0", 4, 54);
    expect_alloc("R10 kept lane1", 4, 55);
    expect_alloc("R11 freed tag", 4, 60);
    chk("R11 drained", cnt(4), 0);
  endtask

  initial begin
    tests = 0; fails = 0;
    rst_n = 1'b0; vec_sel = 1'b0;
    alloc_req = 1'b0; alloc_cls = '0;
    free_vld = 1'b0; free_cls = '0; free_tag = '0;
    bfree_cnt = '0; bfree_cls = '0; bfree_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fifo_underflow();
    t_route_timing();
    t_bad_class();
    t_burst();
    t_zero_burst();
    t_mixed();
    t_mode();
    t_overflow_simul();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule